// File: doc/BRIEF.md
# Byte ALU with Wraparound Flag

This block is the 8-bit arithmetic and logic stage of a processor that has many general registers. It takes a 4-bit operation code, two byte operands and a marker that says whether the optional amount or source operand was supplied. It computes bitwise NOT and AND, increment, decrement, add and subtract. Arithmetic wraps modulo 256. A single wraparound flag records whether the last arithmetic result crossed past 255 or below 0. NOT and AND always clear the flag.

The flag is an ordinary architectural register at index 255. It can therefore be loaded through the normal register write path, which keeps only the low data bit. The operand fetch stage places the current destination value, or the first source, on `opnd_a` and the second value on `opnd_b`. Operation results appear on registered outputs one clock after they are issued, and the flag register updates on that same edge.

Top module: `byte_alu_unit`

## Requirements
- R1: Only six codes are operations: NOT = 4'b0100, AND = 4'b1100, increment = 4'b0010, decrement = 4'b1010, add = 4'b0110, subtract = 4'b1110. Any other code issued with `op_valid` produces no `res_valid`, no `flag_we` and no change to `flag_q`.
- R2: An operation issued with `op_valid` high at a rising edge gives `res_valid = 1` and `flag_we = 1` for exactly the following cycle, together with its `res_data` and `flag_next`.
- R3: NOT returns `~opnd_b` when `amt_present = 1` and `~opnd_a` otherwise, with `flag_next = 0`.
- R4: AND returns `opnd_a & opnd_b` with `flag_next = 0`, whatever the value of `amt_present`.
- R5: Increment returns `(opnd_a + step) mod 256`, where step is `opnd_b` when `amt_present = 1` and 1 otherwise. `flag_next` is 1 exactly when the true sum exceeds 255.
- R6: Decrement returns `(opnd_a - step) mod 256`, with step as in R5. `flag_next` is 1 exactly when step is greater than `opnd_a`.
- R7: Add returns `(opnd_a + opnd_b) mod 256` with `flag_next` = carry out of bit 7. `amt_present` has no effect.
- R8: Subtract returns `(opnd_a - opnd_b) mod 256` with `flag_next = 1` exactly when `opnd_b > opnd_a`. `amt_present` has no effect.
- R9: `flag_q` takes the value of `flag_next` on the edge that raises `flag_we`, and holds its value in cycles with no flag write.
- R10: A register write (`reg_wr_en = 1`) to index 255 stores `reg_wr_data[0]` into `flag_q` at the next edge. Writes to indices 0 to 254 leave `flag_q` unchanged.
- R11: When an operation and a register write to index 255 fall on the same edge, the operation's flag value is stored.
- R12: While `rst` is high at a rising edge, `res_valid`, `flag_we`, `res_data`, `flag_next` and `flag_q` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue the operation on `op_code` this cycle |
| op_code | input | 4 | Operation code |
| opnd_a | input | 8 | Destination value or first source |
| opnd_b | input | 8 | Optional amount or source value |
| amt_present | input | 1 | The optional operand on `opnd_b` was supplied |
| reg_wr_en | input | 1 | Ordinary register write strobe |
| reg_wr_idx | input | 8 | Register index of that write |
| reg_wr_data | input | 8 | Register write data |
| res_valid | output | 1 | Registered result is valid |
| res_data | output | 8 | Registered result byte |
| flag_next | output | 1 | Flag value produced by the operation |
| flag_we | output | 1 | Flag write enable for the result cycle |
| flag_q | output | 1 | Architectural wraparound flag, register 255 |

## Verification
The assertions assume `op_code`, the operands and `amt_present` are known whenever `op_valid` is high, and that the register write inputs are known whenever `reg_wr_en` is high. Operations may be issued back to back. The stimulus drives every input only on falling edges and holds the strobes low between directed items, so no operand is ever undefined at a sampling edge. Flag-write collisions are created on purpose, with a register write to index 255 in the same cycle as an operation, to cover the priority rule.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOT = 4'b0100,
    OP_AND = 4'b1100,
    OP_INC = 4'b0010,
    OP_DEC = 4'b1010,
    OP_ADD = 4'b0110,
    OP_SUB = 4'b1110
  } alu_op_e;

  function automatic logic is_alu_op(input logic [3:0] code);
    case (code)
      OP_NOT, OP_AND, OP_INC, OP_DEC, OP_ADD, OP_SUB: is_alu_op = 1'b1;
      default:                                        is_alu_op = 1'b0;
    endcase
  endfunction

  function automatic logic is_sub_op(input logic [3:0] code);
    is_sub_op = (code == OP_DEC) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int WIDTH = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  generate
    if (RIPPLE) begin : g_ripple
      // explicit bit-serial chain inside one process
      always_comb begin
        logic c;
        c = carry_in;
        for (int i = 0; i < WIDTH; i++) begin
          sum[i] = in_x[i] ^ in_y[i] ^ c;
          c      = (in_x[i] & in_y[i]) | (c & (in_x[i] ^ in_y[i]));
        end
        carry_out = c;
      end
    end else begin : g_native
      logic [WIDTH:0] wide;
      assign wide      = {1'b0, in_x} + {1'b0, in_y} + {{WIDTH{1'b0}}, carry_in};
      assign sum       = wide[WIDTH-1:0];
      assign carry_out = wide[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              has_amt,
  output logic [DATA_W-1:0] value,
  output logic              wrap,
  output logic              legal
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] rhs;
  logic [DATA_W-1:0] rhs_adj;
  logic [DATA_W-1:0] arith;
  logic              sub_mode;
  logic              cout;

  assign step     = has_amt ? b : ONE;
  assign sub_mode = is_sub_op(code);
  assign legal    = is_alu_op(code);

  always_comb begin
    case (code)
      OP_INC, OP_DEC: rhs = step;
      default:        rhs = b;
    endcase
  end

  // subtraction as a + ~rhs + 1
  assign rhs_adj = rhs ^ {DATA_W{sub_mode}};

  byte_alu_adder #(.WIDTH(DATA_W), .RIPPLE(RIPPLE)) u_adder (
    .in_x      (a),
    .in_y      (rhs_adj),
    .carry_in  (sub_mode),
    .sum       (arith),
    .carry_out (cout)
  );

  always_comb begin
    value = '0;
    wrap  = 1'b0;
    case (code)
      OP_NOT: value = ~(has_amt ? b : a);
      OP_AND: value = a & b;
      OP_INC, OP_ADD: begin
        value = arith;
        wrap  = cout;
      end
      OP_DEC, OP_SUB: begin
        value = arith;
        wrap  = ~cout;   // no carry out means a borrow occurred
      end
      default: begin
        value = '0;
        wrap  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/byte_alu_flag.sv
module byte_alu_flag #(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] FLAG_IDX = {IDX_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alu_we,
  input  logic             alu_val,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_bit,
  output logic             flag
);

  logic reg_hit;
  assign reg_hit = reg_we && (reg_idx == FLAG_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (alu_we) begin
      flag <= alu_val;
    end else if (reg_hit) begin
      flag <= reg_bit;
    end
  end

endmodule

// File: rtl/byte_alu_unit.sv
module byte_alu_unit
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              amt_present,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              flag_next,
  output logic              flag_we,
  output logic              flag_q
);

  localparam logic [IDX_W-1:0] FLAG_IDX = {IDX_W{1'b1}};

  logic [DATA_W-1:0] core_val;
  logic              core_wrap;
  logic              core_legal;
  logic              fire;

  byte_alu_core #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_core (
    .code    (op_code),
    .a       (opnd_a),
    .b       (opnd_b),
    .has_amt (amt_present),
    .value   (core_val),
    .wrap    (core_wrap),
    .legal   (core_legal)
  );

  assign fire = op_valid && core_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      flag_next <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_data  <= core_val;
        flag_next <= core_wrap;
      end
    end
  end

  assign flag_we = res_valid;

  byte_alu_flag #(.IDX_W(IDX_W), .FLAG_IDX(FLAG_IDX)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .alu_we  (fire),
    .alu_val (core_wrap),
    .reg_we  (reg_wr_en),
    .reg_idx (reg_wr_idx),
    .reg_bit (reg_wr_data[0]),
    .flag    (flag_q)
  );

endmodule

// File: rtl/byte_alu_checks.sv
module byte_alu_checks
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              amt_present,
  input logic              reg_wr_en,
  input logic [IDX_W-1:0]  reg_wr_idx,
  input logic              reg_bit0,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              flag_next,
  input logic              flag_we,
  input logic              flag_q
);

  logic [DATA_W:0] add_ext;
  logic            issue;
  logic            flag_hit;

  assign add_ext  = {1'b0, opnd_a} + {1'b0, opnd_b};
  assign issue    = op_valid && is_alu_op(op_code);
  assign flag_hit = reg_wr_en && (reg_wr_idx == {IDX_W{1'b1}});

  AST_ISSUE_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
    issue |=> (res_valid && flag_we)); // R2

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !is_alu_op(op_code)) |=> !res_valid); // R1

  AST_LOGIC_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (issue && (op_code == OP_NOT || op_code == OP_AND)) |=> !flag_next); // R4

  AST_NOT_DEFAULT_SRC: assert property (@(posedge clk) disable iff (rst)
    (issue && op_code == OP_NOT && !amt_present) |=> res_data == ~$past(opnd_a)); // R3

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (issue && op_code == OP_ADD) |=> flag_next == $past(add_ext[DATA_W])); // R7

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (issue && op_code == OP_SUB) |=> flag_next == $past(opnd_b > opnd_a)); // R8

  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> flag_q == flag_next); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!issue && !flag_hit) |=> $stable(flag_q)); // R9

  AST_REG_PATH_BIT0: assert property (@(posedge clk) disable iff (rst)
    (flag_hit && !issue) |=> flag_q == $past(reg_bit0)); // R10

endmodule

bind byte_alu_unit byte_alu_checks #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .amt_present (amt_present),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_idx  (reg_wr_idx),
  .reg_bit0    (reg_wr_data[0]),
  .res_valid   (res_valid),
  .res_data    (res_data),
  .flag_next   (flag_next),
  .flag_we     (flag_we),
  .flag_q      (flag_q)
);

// File: tb/tb_byte_alu_unit.sv
module tb_byte_alu_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'h0;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic       amt_present = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_idx = 8'h00;
  logic [7:0] reg_wr_data = 8'h00;
  logic       res_valid;
  logic [7:0] res_data;
  logic       flag_next;
  logic       flag_we;
  logic       flag_q;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] val;
    logic       flg;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  byte_alu_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .amt_present(amt_present),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .res_valid(res_valid), .res_data(res_data), .flag_next(flag_next),
    .flag_we(flag_we), .flag_q(flag_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic has, input string tag);
    exp_t e;
    int   stp;
    stp = has ? int'(b) : 1;
    e.tag = tag;
    e.flg = 1'b0;
    case (op)
      4'b0100: e.val = has ? ~b : ~a;
      4'b1100: e.val = a & b;
      4'b0010: begin e.val = 8'(int'(a) + stp); e.flg = (int'(a) + stp) > 255; end
      4'b1010: begin e.val = 8'(int'(a) - stp); e.flg = stp > int'(a); end
      4'b0110: begin e.val = 8'(int'(a) + int'(b)); e.flg = (int'(a) + int'(b)) > 255; end
      4'b1110: begin e.val = 8'(int'(a) - int'(b)); e.flg = b > a; end
      default: e.val = 8'h00;
    endcase
    return e;
  endfunction

  function automatic bit legal(input logic [3:0] op);
    return op inside {4'b0100, 4'b1100, 4'b0010, 4'b1010, 4'b0110, 4'b1110};
  endfunction

  // driver: issue one operation at a falling edge, queue its expectation
  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic has, input string tag);
    @(negedge clk);
    op_valid    = 1'b1;
    op_code     = op;
    opnd_a      = a;
    opnd_b      = b;
    amt_present = has;
    if (legal(op)) exp_q.push_back(model(op, a, b, has, tag));
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] data);
    @(negedge clk);
    op_valid    = 1'b0;
    reg_wr_en   = 1'b1;
    reg_wr_idx  = idx;
    reg_wr_data = data;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid  = 1'b0;
    reg_wr_en = 1'b0;
  endtask

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_data == e.val, {e.tag, " result"}, res_data, e.val);
        check(flag_next == e.flg, {e.tag, " flag_next"}, flag_next, e.flg);
        check(flag_we == 1'b1, {e.tag, " R2 flag_we"}, flag_we, 1);
        check(flag_q == e.flg, {e.tag, " R9 flag_q"}, flag_q, e.flg);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b0 && flag_we == 1'b0, "R12 strobes after reset", res_valid, 0);
    check(res_data == 8'h00 && flag_next == 1'b0, "R12 data after reset", res_data, 0);
    check(flag_q == 1'b0, "R12 flag after reset", flag_q, 0);
    rst = 1'b0;

    // R3 NOT with and without source operand
    drive(4'b0100, 8'h5A, 8'h0F, 1'b0, "R3 not-a");
    drive(4'b0100, 8'h5A, 8'h0F, 1'b1, "R3 not-b");
    // R4 AND, marker irrelevant
    drive(4'b1100, 8'hF0, 8'h3C, 1'b0, "R4 and");
    drive(4'b1100, 8'hF0, 8'h3C, 1'b1, "R4 and-amt");
    // R5 increment
    drive(4'b0010, 8'h10, 8'h00, 1'b0, "R5 inc-1");
    drive(4'b0010, 8'hFF, 8'h00, 1'b0, "R5 inc-wrap");
    drive(4'b0010, 8'hF0, 8'h20, 1'b1, "R5 inc-amt-wrap");
    drive(4'b0010, 8'h00, 8'h00, 1'b1, "R5 inc-zero");
    // R6 decrement
    drive(4'b1010, 8'h00, 8'h00, 1'b0, "R6 dec-wrap");
    drive(4'b1010, 8'h01, 8'h00, 1'b0, "R6 dec-to-zero");
    drive(4'b1010, 8'h05, 8'h06, 1'b1, "R6 dec-amt-wrap");
    drive(4'b1010, 8'h80, 8'h80, 1'b1, "R6 dec-amt-equal");
    // R7 add
    drive(4'b0110, 8'h7F, 8'h01, 1'b0, "R7 add");
    drive(4'b0110, 8'h80, 8'h80, 1'b1, "R7 add-wrap");
    drive(4'b0110, 8'hFF, 8'h00, 1'b0, "R7 add-edge");
    // R8 subtract
    drive(4'b1110, 8'h10, 8'h01, 1'b1, "R8 sub");
    drive(4'b1110, 8'h00, 8'h01, 1'b0, "R8 sub-wrap");
    drive(4'b1110, 8'h33, 8'h33, 1'b0, "R8 sub-equal");
    idle();
    idle();

    // R1 non-operation codes produce nothing and leave the flag alone
    begin
      logic keep;
      keep = flag_q;
      drive(4'b0000, 8'hFF, 8'hFF, 1'b1, "R1");
      drive(4'b1111, 8'hFF, 8'hFF, 1'b1, "R1");
      @(negedge clk);
      check(res_valid == 1'b0, "R1 no result for code 4'b0000/4'b1111", res_valid, 0);
      check(flag_we == 1'b0, "R1 no flag write", flag_we, 0);
      idle();
      check(flag_q == keep, "R1 flag unchanged", flag_q, keep);
    end

    // R10 register path
    reg_write(8'hFF, 8'h03);
    idle();
    check(flag_q == 1'b1, "R10 bit0=1 stored", flag_q, 1);
    reg_write(8'hFE, 8'h00);
    idle();
    check(flag_q == 1'b1, "R10 index 254 ignored", flag_q, 1);
    reg_write(8'hFF, 8'hFE);
    idle();
    check(flag_q == 1'b0, "R10 bit0=0 stored", flag_q, 0);

    // R9 hold across idle cycles
    repeat (3) idle();
    check(flag_q == 1'b0, "R9 flag holds", flag_q, 0);

    // R11 operation beats register write on the same edge
    drive(4'b0010, 8'hFF, 8'h00, 1'b0, "R11 inc-wrap vs reg 0");
    reg_wr_en = 1'b1; reg_wr_idx = 8'hFF; reg_wr_data = 8'h00;
    drive(4'b1100, 8'hFF, 8'hFF, 1'b0, "R11 and vs reg 1");
    reg_wr_data = 8'h01;
    idle();
    idle();
    check(flag_q == 1'b0, "R11 flag after collisions", flag_q, 0);

    idle();
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule